// File: doc/BRIEF.md
# Four-Phase Command Mailbox

This block sits between a host and a back-end engine. The host sees two 32-bit words. It writes a command word and polls a status word. The command word carries four things: a request flag, a write flag, an 8-bit opcode and a 12-bit argument. When the request flag goes from 0 to 1, the block latches the command. It then gives the engine a single-cycle dispatch strobe with the opcode, the write flag and the argument. The block marks itself busy until the engine reports completion.

Completion is reported by an acknowledge flag in the status word. The acknowledge stays up until the host drops its request, and it falls one cycle after that. For read-type commands, the engine's 16-bit reply is shown in the upper half of the status word while the acknowledge is high. An opcode outside the known set is never sent to the engine. It is still acknowledged, with a zero reply, so a host never waits forever.

Top module: `cmd_mailbox`

## Requirements
- R1: The command word updates on every cycle with `cmd_we` high. A command is taken only when command bit 15 (request) goes from 0 to 1 while the block is idle. A write that keeps bit 15 at 1 starts nothing.
- R2: Each accepted known command gives exactly one `be_strobe` pulse, one cycle long. The pulse is high in the second cycle after the write that raised the request. `be_opcode` carries command bits 7:0, `be_write` carries bit 13 and `be_arg` carries bits 27:16.
- R3: Status bit 14 (busy) rises one cycle after the request write. It stays high until the cycle after the engine's done is sampled.
- R4: Status bit 15 (acknowledge) rises on the same edge that clears busy. Acknowledge and busy are never high together.
- R5: Acknowledge stays high while the request is 1. It falls exactly one cycle after the host's write that clears the request.
- R6: For a read command (bit 13 = 0), status bits 31:16 show the `be_rdata` value sampled together with `be_done`, while acknowledge is high. At all other times these bits are zero.
- R7: For a write command (bit 13 = 1), status bits 31:16 read zero even while acknowledge is high.
- R8: Eight opcodes are known: 0x40, 0x41, 0x45, 0x0F, 0x49, 0x4A, 0x4B and 0x4C. Any other opcode produces no strobe, one cycle of busy, an acknowledge and a zero reply.
- R9: A request that is cleared and raised again while a command is in progress is ignored. No further strobe is issued for it.
- R10: After reset the status word is zero and no strobe is pending. Status bits 13:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Write enable for the command word |
| cmd_wdata | input | 32 | New command word value |
| status_word | output | 32 | Status word: reply, acknowledge and busy |
| be_strobe | output | 1 | One-cycle dispatch strobe to the engine |
| be_opcode | output | 8 | Opcode of the dispatched command |
| be_write | output | 1 | Write flag of the dispatched command |
| be_arg | output | 12 | Argument of the dispatched command |
| be_done | input | 1 | Engine completion pulse |
| be_rdata | input | 16 | Engine reply, valid with `be_done` |

## Verification
A stuck or wrong control phase shows at the ports within one or two cycles of the request edge. The symptom is a missing, doubled or misplaced strobe, or busy and acknowledge bits that break the poll sequence. A wrong or stale reply register shows as nonzero upper status bits while acknowledge is low, or as the wrong reply while it is high. The reference model is compared against the status word and the strobe bundle on every clock, so such a fault is reported in the cycle it first appears.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   localparam int OPC_W = 8;
   localparam int N_OPS = 8;

   // Opcodes the back end understands; anything else is answered locally.
   localparam logic [OPC_W-1:0] OP_TABLE [N_OPS] = '{
      8'h40, 8'h41, 8'h45, 8'h0F, 8'h49, 8'h4A, 8'h4B, 8'h4C
   };

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WAIT = 2'd1,
      PH_SKIP = 2'd2,
      PH_ACK  = 2'd3
   } phase_t;

endpackage

// File: rtl/mbx_cmd_reg.sv
module mbx_cmd_reg #(
   parameter int DATA_W  = 32,
   parameter int REQ_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] word_q,
   output logic              req_lvl,
   output logic              req_rise
);

   logic req_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         req_prev <= 1'b0;
      end else begin
         if (wr_en) word_q <= wr_data;
         req_prev <= word_q[REQ_BIT];
      end
   end

   assign req_lvl  = word_q[REQ_BIT];
   assign req_rise = word_q[REQ_BIT] & ~req_prev;

endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int WR_BIT  = 13,
   parameter int ARG_LSB = 16,
   parameter int ARG_W   = 12
) (
   input  logic [DATA_W-1:0] word,
   output logic [OPC_W-1:0]  opcode,
   output logic              is_write,
   output logic [ARG_W-1:0]  arg,
   output logic              known
);

   logic [N_OPS-1:0] hit;

   assign opcode   = word[OPC_W-1:0];
   assign is_write = word[WR_BIT];
   assign arg      = word[ARG_LSB +: ARG_W];

   for (genvar i = 0; i < N_OPS; i++) begin : g_match
      assign hit[i] = (opcode == OP_TABLE[i]);
   end

   assign known = |hit;

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
#(
   parameter int ARG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_lvl,
   input  logic             req_rise,
   input  logic [OPC_W-1:0] dec_opcode,
   input  logic             dec_write,
   input  logic [ARG_W-1:0] dec_arg,
   input  logic             dec_known,
   input  logic             be_done,
   output logic             be_strobe,
   output logic [OPC_W-1:0] be_opcode,
   output logic             be_write,
   output logic [ARG_W-1:0] be_arg,
   output logic             busy,
   output logic             ack,
   output logic             cap_en,
   output logic             cap_zero,
   output logic             drop
);

   phase_t           phase;
   logic [OPC_W-1:0] lat_op;
   logic             lat_wr;
   logic [ARG_W-1:0] lat_arg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         busy      <= 1'b0;
         ack       <= 1'b0;
         be_strobe <= 1'b0;
         lat_op    <= '0;
         lat_wr    <= 1'b0;
         lat_arg   <= '0;
      end else begin
         be_strobe <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (req_rise) begin
                  busy    <= 1'b1;
                  lat_op  <= dec_opcode;
                  lat_wr  <= dec_write;
                  lat_arg <= dec_arg;
                  if (dec_known) begin
                     be_strobe <= 1'b1;
                     phase     <= PH_WAIT;
                  end else begin
                     phase <= PH_SKIP;
                  end
               end
            end
            PH_WAIT: begin
               if (be_done) begin
                  busy  <= 1'b0;
                  ack   <= 1'b1;
                  phase <= PH_ACK;
               end
            end
            PH_SKIP: begin
               busy  <= 1'b0;
               ack   <= 1'b1;
               phase <= PH_ACK;
            end
            PH_ACK: begin
               if (!req_lvl) begin
                  ack   <= 1'b0;
                  phase <= PH_IDLE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign cap_en    = ((phase == PH_WAIT) && be_done) || (phase == PH_SKIP);
   assign cap_zero  = (phase == PH_SKIP) || lat_wr;
   assign drop      = (phase == PH_ACK) && !req_lvl;
   assign be_opcode = lat_op;
   assign be_write  = lat_wr;
   assign be_arg    = lat_arg;

endmodule

// File: rtl/mbx_reply.sv
module mbx_reply #(
   parameter int RDATA_W       = 16,
   parameter bit CLEAR_ON_DROP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic               cap_zero,
   input  logic               drop,
   input  logic               ack,
   input  logic [RDATA_W-1:0] rdata,
   output logic [RDATA_W-1:0] reply
);

   logic [RDATA_W-1:0] reply_q;

   if (CLEAR_ON_DROP) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      reply_q <= '0;
         else if (cap_en) reply_q <= cap_zero ? '0 : rdata;
         else if (drop)   reply_q <= '0;
      end
      assign reply = reply_q;
   end else begin : g_mask
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      reply_q <= '0;
         else if (cap_en) reply_q <= cap_zero ? '0 : rdata;
      end
      assign reply = ack ? reply_q : '0;
   end

endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
   import mbx_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int REQ_BIT       = 15,
   parameter int BUSY_BIT      = 14,
   parameter int WR_BIT        = 13,
   parameter int ARG_LSB       = 16,
   parameter int ARG_W         = 12,
   parameter int REPLY_LSB     = 16,
   parameter int RDATA_W       = 16,
   parameter bit CLEAR_ON_DROP = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_we,
   input  logic [DATA_W-1:0]  cmd_wdata,
   output logic [DATA_W-1:0]  status_word,
   output logic               be_strobe,
   output logic [OPC_W-1:0]   be_opcode,
   output logic               be_write,
   output logic [ARG_W-1:0]   be_arg,
   input  logic               be_done,
   input  logic [RDATA_W-1:0] be_rdata
);

   localparam int ARG_MSB   = ARG_LSB + ARG_W - 1;
   localparam int REPLY_MSB = REPLY_LSB + RDATA_W - 1;

   if (ARG_MSB >= DATA_W) begin : g_bad_arg
      $error("argument field does not fit in the command word");
   end
   if (REPLY_MSB >= DATA_W) begin : g_bad_reply
      $error("reply field does not fit in the status word");
   end
   if (REQ_BIT < OPC_W || BUSY_BIT < OPC_W || WR_BIT < OPC_W) begin : g_bad_flags
      $error("flag bits overlap the opcode");
   end
   if (REQ_BIT == BUSY_BIT || REPLY_LSB <= REQ_BIT || REPLY_LSB <= BUSY_BIT) begin : g_bad_status
      $error("status fields overlap");
   end

   logic [DATA_W-1:0]  word_q;
   logic               req_lvl;
   logic               req_rise;
   logic [OPC_W-1:0]   dec_opcode;
   logic               dec_write;
   logic [ARG_W-1:0]   dec_arg;
   logic               dec_known;
   logic               busy;
   logic               ack;
   logic               cap_en;
   logic               cap_zero;
   logic               drop;
   logic [RDATA_W-1:0] reply;

   mbx_cmd_reg #(.DATA_W(DATA_W), .REQ_BIT(REQ_BIT)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmd_we),
      .wr_data  (cmd_wdata),
      .word_q   (word_q),
      .req_lvl  (req_lvl),
      .req_rise (req_rise)
   );

   mbx_decode #(.DATA_W(DATA_W), .WR_BIT(WR_BIT), .ARG_LSB(ARG_LSB), .ARG_W(ARG_W)) u_dec (
      .word     (word_q),
      .opcode   (dec_opcode),
      .is_write (dec_write),
      .arg      (dec_arg),
      .known    (dec_known)
   );

   mbx_ctrl #(.ARG_W(ARG_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_lvl    (req_lvl),
      .req_rise   (req_rise),
      .dec_opcode (dec_opcode),
      .dec_write  (dec_write),
      .dec_arg    (dec_arg),
      .dec_known  (dec_known),
      .be_done    (be_done),
      .be_strobe  (be_strobe),
      .be_opcode  (be_opcode),
      .be_write   (be_write),
      .be_arg     (be_arg),
      .busy       (busy),
      .ack        (ack),
      .cap_en     (cap_en),
      .cap_zero   (cap_zero),
      .drop       (drop)
   );

   mbx_reply #(.RDATA_W(RDATA_W), .CLEAR_ON_DROP(CLEAR_ON_DROP)) u_reply (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_zero (cap_zero),
      .drop     (drop),
      .ack      (ack),
      .rdata    (be_rdata),
      .reply    (reply)
   );

   always_comb begin
      status_word = '0;
      status_word[REQ_BIT]  = ack;
      status_word[BUSY_BIT] = busy;
      status_word[REPLY_LSB +: RDATA_W] = reply;
   end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
   parameter int RDATA_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_lvl,
   input logic               busy,
   input logic               ack,
   input logic [RDATA_W-1:0] reply,
   input logic               be_strobe
);

   // R2: the dispatch strobe lasts a single cycle
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      be_strobe |=> !be_strobe);

   // R3: a strobe only appears while busy is up
   a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      be_strobe |-> busy);

   // R3: busy starts only after a fresh request edge
   a_r3_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(req_lvl) && !$past(req_lvl, 2)));

   // R4: acknowledge and busy are exclusive
   a_r4_no_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack && busy));

   // R4: acknowledge rises only when busy was up just before
   a_r4_ack_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(busy));

   // R5: acknowledge holds while the request is held
   a_r5_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req_lvl) |=> ack);

   // R5: acknowledge drops one cycle after the request is gone
   a_r5_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !req_lvl) |=> !ack);

   // R6: no reply is visible without acknowledge
   a_r6_reply_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> (reply == '0));

endmodule

bind cmd_mailbox mbx_checker #(.RDATA_W(RDATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_lvl   (req_lvl),
   .busy      (busy),
   .ack       (ack),
   .reply     (reply),
   .be_strobe (be_strobe)
);

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_we;
   logic [31:0] cmd_wdata;
   logic        be_done;
   logic [15:0] be_rdata;
   logic [31:0] status_word;
   logic        be_strobe;
   logic [7:0]  be_opcode;
   logic        be_write;
   logic [11:0] be_arg;

   always #10 clk = ~clk;

   cmd_mailbox u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (cmd_we),
      .cmd_wdata   (cmd_wdata),
      .status_word (status_word),
      .be_strobe   (be_strobe),
      .be_opcode   (be_opcode),
      .be_write    (be_write),
      .be_arg      (be_arg),
      .be_done     (be_done),
      .be_rdata    (be_rdata)
   );

   int checks = 0;
   int errors = 0;
   int strobe_cnt = 0;
   int bdelay = 0;
   int pend = -1;
   logic [15:0] bdata = 16'h0;
   bit finished = 1'b0;

   // reference model state
   logic [31:0] m_cmd;
   bit          m_prev, m_busy, m_ack, m_strobe, m_wr;
   logic [15:0] m_reply;
   logic [7:0]  m_op;
   logic [11:0] m_arg;
   int          m_phase;   // 0 idle, 1 waiting on engine, 2 local answer, 3 acknowledged

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic bit op_known(input logic [7:0] op);
      case (op)
         8'h0F, 8'h40, 8'h41, 8'h45, 8'h49, 8'h4A, 8'h4B, 8'h4C: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // model step and per-cycle comparison
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         m_cmd = 0; m_prev = 0; m_busy = 0; m_ack = 0; m_strobe = 0;
         m_reply = 0; m_phase = 0; m_op = 0; m_arg = 0; m_wr = 0;
      end else begin
         bit req;
         req = m_cmd[15];
         m_strobe = 0;
         if (m_phase == 0) begin
            if (req && !m_prev) begin
               m_busy = 1;
               m_op = m_cmd[7:0]; m_wr = m_cmd[13]; m_arg = m_cmd[27:16];
               if (op_known(m_op)) begin m_strobe = 1; m_phase = 1; end
               else m_phase = 2;
            end
         end else if (m_phase == 1) begin
            if (be_done) begin
               m_busy = 0; m_ack = 1; m_phase = 3;
               m_reply = m_wr ? 16'h0 : be_rdata;
            end
         end else if (m_phase == 2) begin
            m_busy = 0; m_ack = 1; m_phase = 3; m_reply = 0;
         end else begin
            if (!req) begin m_ack = 0; m_phase = 0; end
         end
         m_prev = req;
         if (cmd_we) m_cmd = cmd_wdata;

         chk(status_word[15] === m_ack, "R4/R5", "ack bit", {31'b0, status_word[15]}, {31'b0, m_ack});
         chk(status_word[14] === m_busy, "R3", "busy bit", {31'b0, status_word[14]}, {31'b0, m_busy});
         chk(status_word[31:16] === (m_ack ? m_reply : 16'h0), "R6/R7", "reply",
             {16'b0, status_word[31:16]}, {16'b0, (m_ack ? m_reply : 16'h0)});
         chk(status_word[13:0] === 14'h0, "R10", "low status", {18'b0, status_word[13:0]}, 32'h0);
         chk(be_strobe === m_strobe, "R2", "strobe", {31'b0, be_strobe}, {31'b0, m_strobe});
         if (m_strobe) begin
            chk(be_opcode === m_op, "R2", "opcode", {24'b0, be_opcode}, {24'b0, m_op});
            chk(be_write === m_wr, "R2", "write flag", {31'b0, be_write}, {31'b0, m_wr});
            chk(be_arg === m_arg, "R2", "argument", {20'b0, be_arg}, {20'b0, m_arg});
         end
         if (be_strobe === 1'b1) strobe_cnt++;
      end
   end

   // back-end engine: done a programmable number of cycles after a strobe
   always @(posedge clk) begin
      #4;
      if (!rst_n) begin
         be_done = 0; be_rdata = 0; pend = -1;
      end else begin
         be_done = 0;
         be_rdata = ~bdata;
         if (be_strobe) pend = bdelay;
         if (pend == 0) begin
            be_done = 1; be_rdata = bdata; pend = -1;
         end else if (pend > 0) begin
            pend--;
         end
      end
   end

   task automatic hwrite(input logic [31:0] w);
      @(posedge clk); #4;
      cmd_we = 1; cmd_wdata = w;
      @(posedge clk); #4;
      cmd_we = 0;
   endtask

   task automatic wait_ack(input logic v);
      for (int i = 0; i < 80; i++) begin
         if (status_word[15] === v) break;
         @(posedge clk); #3;
      end
   endtask

   task automatic finish_run;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      int s0;
      logic [15:0] seen;
      rst_n = 0; cmd_we = 0; cmd_wdata = 0;
      repeat (3) @(posedge clk);
      #4; rst_n = 1;
      @(posedge clk); #3;
      // R10: reset state
      chk(status_word === 32'h0, "R10", "status after reset", status_word, 32'h0);
      chk(be_strobe === 1'b0, "R10", "strobe after reset", {31'b0, be_strobe}, 32'h0);

      // R6 / R3: read command with delayed engine
      bdelay = 3; bdata = 16'hBEEF; s0 = strobe_cnt;
      hwrite(32'h0000_804A);
      chk(status_word[14] === 1'b0, "R3", "busy not yet", {31'b0, status_word[14]}, 32'h0);
      @(posedge clk); #3;
      chk(status_word[14] === 1'b1, "R3", "busy one cycle later", {31'b0, status_word[14]}, 32'h1);
      wait_ack(1'b1);
      seen = status_word[31:16];
      chk(seen === 16'hBEEF, "R6", "read reply", {16'b0, seen}, 32'h0000_BEEF);
      hwrite(32'h0000_004A);
      wait_ack(1'b0);
      chk(strobe_cnt - s0 == 1, "R2", "strobes per read", strobe_cnt - s0, 1);

      // R7: write command, engine answers at once
      bdelay = 0; bdata = 16'h1234; s0 = strobe_cnt;
      hwrite(32'h030C_A041);
      wait_ack(1'b1);
      chk(status_word[15] === 1'b1, "R4", "ack for write", {31'b0, status_word[15]}, 32'h1);
      chk(status_word[31:16] === 16'h0, "R7", "write reply zero", {16'b0, status_word[31:16]}, 32'h0);
      hwrite(32'h030C_2041);
      wait_ack(1'b0);
      chk(strobe_cnt - s0 == 1, "R2", "strobes per write", strobe_cnt - s0, 1);

      // R8: unknown opcode
      bdata = 16'hAAAA; s0 = strobe_cnt;
      hwrite(32'h0000_8077);
      wait_ack(1'b1);
      chk(status_word[15] === 1'b1, "R8", "unknown acked", {31'b0, status_word[15]}, 32'h1);
      chk(status_word[31:16] === 16'h0, "R8", "unknown reply", {16'b0, status_word[31:16]}, 32'h0);
      hwrite(32'h0000_0077);
      wait_ack(1'b0);
      chk(strobe_cnt - s0 == 0, "R8", "no strobe for unknown", strobe_cnt - s0, 0);

      // R1: rewrite with request still set starts nothing
      bdelay = 1; bdata = 16'h5A5A; s0 = strobe_cnt;
      hwrite(32'h0000_804B);
      wait_ack(1'b1);
      bdata = 16'h0F0F;
      hwrite(32'h0000_804C);
      repeat (4) @(posedge clk);
      #3;
      chk(strobe_cnt - s0 == 1, "R1", "held request no redispatch", strobe_cnt - s0, 1);
      chk(status_word[31:16] === 16'h5A5A, "R1", "reply unchanged", {16'b0, status_word[31:16]}, 32'h5A5A);
      hwrite(32'h0000_004C);
      wait_ack(1'b0);

      // R9: request toggled while the engine is working
      bdelay = 10; bdata = 16'hC0DE; s0 = strobe_cnt;
      hwrite(32'h0000_8049);
      hwrite(32'h0000_0049);
      hwrite(32'h0000_8049);
      wait_ack(1'b1);
      // R5: acknowledge held with request held
      repeat (20) @(posedge clk);
      #3;
      chk(status_word[15] === 1'b1, "R5", "ack held", {31'b0, status_word[15]}, 32'h1);
      hwrite(32'h0000_0049);
      chk(status_word[15] === 1'b1, "R5", "ack still up at clear", {31'b0, status_word[15]}, 32'h1);
      @(posedge clk); #3;
      chk(status_word[15] === 1'b0, "R5", "ack fell one cycle later", {31'b0, status_word[15]}, 32'h0);
      chk(strobe_cnt - s0 == 1, "R9", "retoggle ignored", strobe_cnt - s0, 1);

      // R6: reply gone once acknowledge dropped
      repeat (3) @(posedge clk);
      #3;
      chk(status_word === 32'h0, "R6", "idle status", status_word, 32'h0);

      finish_run();
   end

endmodule